// File: doc/BRIEF.md
# Serial Flash OTP Read Responder

This block is the device-side logic inside a serial flash that serves reads of the one-time-programmable area over a single-bit SPI link in mode 0. The host lowers chip select and sends an instruction byte. It then sends an address of 24 or 32 bits, chosen by the addressing-mode input, followed by eight dummy clocks. After that the block sends back OTP bytes, most significant bit first, stepping to the next address after each byte until chip select rises.

The OTP contents come from an external register array. The block presents a 7-bit index to the array and reads back one byte combinationally. The serial output is a pad pair: a data bit and an output-enable. The pad drives the line only while the enable is high and leaves it floating otherwise. The read window is 65 bytes and never wraps. A separate flag marks any byte whose full address falls outside the window, and the value on the line for such a byte is meaningless. When the program/erase engine reports busy, the command is refused and has no effect on the running cycle.

Top module: `otp_read_responder`

## Requirements
- R1: While chip select is high, and through the instruction, address and dummy phases, the output-enable `so_oe` is 0.
- R2: Input bits are taken on the rising serial clock edge, MSB first. An instruction byte other than the `OPCODE` parameter (default 8'h4B) keeps `so_oe` at 0 until chip select rises.
- R3: If `wip` is 1 at the rising edge that takes the eighth instruction bit, the command is refused and `so_oe` stays 0 for the rest of the transaction.
- R4: With `addr4_en` at 0, the address is 24 bits. The first data bit is driven on the falling edge that follows rising edge 40.
- R5: With `addr4_en` at 1, the address is 32 bits. The first data bit is driven on the falling edge that follows rising edge 48.
- R6: Data bits change on falling edges, MSB first, and each byte equals `otp_rdata` for the index shown on `otp_idx` during that byte.
- R7: After each data byte the address rises by one. `otp_idx` shows bits 6:0 of the current address and does not roll back to 0 past the end of the window.
- R8: `oor` is 1 during the data phase exactly when the full current address is 65 or more. Such bytes are don't-care.
- R9: Raising chip select at any point, including mid-byte, ends the command, and the next transaction decodes from its first bit.
- R10: `addr4_en` and `wip` are sampled at the eighth instruction bit, and the captured address stays fixed for the whole data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cs_n | input | 1 | Chip select, active low; high also clears all state |
| sclk | input | 1 | Serial clock, idles low |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out bit to the pad |
| so_oe | output | 1 | Pad drive enable for `so` |
| wip | input | 1 | Program/erase/write cycle in progress |
| addr4_en | input | 1 | Selects 32-bit addressing |
| otp_idx | output | 7 | Index into the OTP array |
| otp_rdata | input | 8 | Array byte at `otp_idx` |
| oor | output | 1 | Current byte lies outside the 65-byte window |

## Verification
The bench sweeps every start address of the window in both addressing modes and reads two bytes each time. This covers the step from byte 64 to 65, where a wrapping design would return byte 0 or lower the range flag. It also catches a header counted with the wrong length, because such a design would enable the pad one byte early or late. A 32-bit address whose low bits fall inside the window must still be flagged, so a design that compared only the 7-bit index would fail. Refused commands (busy or a wrong opcode) must never enable the pad. A mid-byte abort followed by a fresh read catches a bit counter or byte counter that survives chip select.

// File: rtl/otp_read_responder.sv
module otp_read_responder #(
  parameter logic [7:0] OPCODE    = 8'h4B,
  parameter int         OTP_BYTES = 65,
  parameter int         IDX_W     = 7,
  parameter int         CNT_W     = 16
) (
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             si,
  output logic             so,
  output logic             so_oe,
  input  logic             wip,
  input  logic             addr4_en,
  output logic [IDX_W-1:0] otp_idx,
  input  logic [7:0]       otp_rdata,
  output logic             oor
);
  localparam int HDR3_I = 8 + 24 + 8;
  localparam int HDR4_I = 8 + 32 + 8;
  localparam int HCW    = $clog2(HDR4_I + 1);
  localparam logic [HCW-1:0] HDR3    = HCW'(HDR3_I);
  localparam logic [HCW-1:0] HDR4    = HCW'(HDR4_I);
  localparam logic [HCW-1:0] OP_LAST = HCW'(7);

  logic [HCW-1:0]   cnt;
  logic [6:0]       sh;
  logic [31:0]      addr_rx;
  logic             acc, m4;
  logic [2:0]       bidx;
  logic [CNT_W-1:0] byte_cnt;
  logic             dout, oe;

  wire [HCW-1:0] hdr_len  = m4 ? HDR4 : HDR3;
  wire [HCW-1:0] addr_end = m4 ? HCW'(40) : HCW'(32);
  wire           data_ph  = acc && (cnt == hdr_len);
  wire [31:0]    cur_addr = addr_rx + 32'(byte_cnt);

  always_ff @(posedge sclk or posedge cs_n) begin
    if (cs_n) begin
      cnt     <= '0;
      sh      <= '0;
      addr_rx <= '0;
      acc     <= 1'b0;
      m4      <= 1'b0;
    end else begin
      if (cnt < hdr_len) cnt <= cnt + 1'b1;
      if (cnt < HCW'(8)) begin
        sh <= {sh[5:0], si};
        if (cnt == OP_LAST) begin
          acc <= ({sh, si} == OPCODE) && !wip;
          m4  <= addr4_en;
        end
      end else if (cnt < addr_end) begin
        addr_rx <= {addr_rx[30:0], si};
      end
    end
  end

  always_ff @(negedge sclk or posedge cs_n) begin
    if (cs_n) begin
      oe       <= 1'b0;
      dout     <= 1'b0;
      bidx     <= '0;
      byte_cnt <= '0;
    end else if (data_ph) begin
      oe   <= 1'b1;
      dout <= otp_rdata[~bidx];
      bidx <= bidx + 1'b1;
      if (bidx == 3'd7) byte_cnt <= byte_cnt + 1'b1;
    end
  end

  assign so      = dout;
  assign so_oe   = oe;
  assign otp_idx = cur_addr[IDX_W-1:0];
  assign oor     = data_ph && (cur_addr >= 32'(OTP_BYTES));
endmodule

// File: rtl/otp_read_responder_chk.sv
module otp_read_responder_chk #(
  parameter int HCW   = 6,
  parameter int CNT_W = 16
) (
  input logic             cs_n,
  input logic             sclk,
  input logic             oe,
  input logic             acc,
  input logic [HCW-1:0]   cnt,
  input logic [HCW-1:0]   hdr_len,
  input logic [2:0]       bidx,
  input logic [CNT_W-1:0] byte_cnt,
  input logic [31:0]      addr_rx
);
  // R1
  hdr_quiet_chk: assert property (@(posedge sclk) disable iff (cs_n)
    (cnt < hdr_len) |-> !oe);

  // R3
  refused_quiet_chk: assert property (@(posedge sclk) disable iff (cs_n)
    !acc |-> !oe);

  // R7
  byte_step_chk: assert property (@(negedge sclk) disable iff (cs_n)
    (oe && bidx == 3'd0) |-> (byte_cnt == $past(byte_cnt) + 1'b1));

  // R10
  addr_frozen_chk: assert property (@(posedge sclk) disable iff (cs_n)
    (acc && cnt == hdr_len && $past(cnt) == hdr_len) |-> $stable(addr_rx));
endmodule

bind otp_read_responder otp_read_responder_chk #(.HCW(HCW), .CNT_W(CNT_W)) chk (
  .cs_n(cs_n), .sclk(sclk), .oe(oe), .acc(acc), .cnt(cnt), .hdr_len(hdr_len),
  .bidx(bidx), .byte_cnt(byte_cnt), .addr_rx(addr_rx)
);

// File: tb/tb_otp_read_responder.sv
module tb_otp_read_responder;
  logic       cs_n = 1'b1, sclk = 1'b0, si = 1'b0, wip = 1'b0, addr4_en = 1'b0;
  logic       so, so_oe, oor;
  logic [6:0] otp_idx;
  logic [7:0] otp_rdata;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  otp_read_responder dut (
    .cs_n(cs_n), .sclk(sclk), .si(si), .so(so), .so_oe(so_oe), .wip(wip),
    .addr4_en(addr4_en), .otp_idx(otp_idx), .otp_rdata(otp_rdata), .oor(oor)
  );

  function automatic logic [7:0] pat(input logic [6:0] a);
    return 8'({1'b0, a} * 8'd37 + 8'd11);
  endfunction
  assign otp_rdata = pat(otp_idx);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // 250 MHz serial clock: one bit every 4 ns
  task automatic tick(input logic b);
    si = b; #1 sclk = 1'b1; #2 sclk = 1'b0; #1;
  endtask

  task automatic send(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) tick(v[i]);
  endtask

  task automatic start_rd(input logic [7:0] opc, input logic [31:0] a, input logic m4,
                          input logic busy, input bit expect_on);
    addr4_en = m4; wip = busy; cs_n = 1'b0; #2;
    send(32'(opc), 8);
    wip = 1'b0;
    send(a, m4 ? 32 : 24);
    send(0, 7);
    chk(so_oe == 1'b0, "R1 header quiet", so_oe, 0);
    tick(1'b0);
    if (expect_on) chk(so_oe == 1'b1, m4 ? "R5 data start" : "R4 data start", so_oe, 1);
  endtask

  task automatic get_byte(output logic [7:0] b, output logic [6:0] idx, output logic fl);
    idx = otp_idx; fl = oor;
    for (int i = 7; i >= 0; i--) begin
      b[i] = so;
      tick(1'b0);
    end
  endtask

  task automatic stop_rd();
    cs_n = 1'b1; #4;
  endtask

  initial begin
    #800000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] b;
    logic [6:0] idx;
    logic fl;
    #5;
    chk(so_oe == 1'b0, "R1 idle", so_oe, 0);

    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 65; s++) begin
        start_rd(8'h4B, 32'(s), m[0], 1'b0, 1'b1);
        get_byte(b, idx, fl);
        chk(idx == 7'(s), "R7 start index", idx, s);
        chk(fl == 1'b0, "R8 in range", fl, 0);
        chk(b == pat(7'(s)), "R6 byte0", b, pat(7'(s)));
        get_byte(b, idx, fl);
        chk(idx == 7'(s + 1), "R7 next index no wrap", idx, s + 1);
        if (s + 1 < 65) chk(b == pat(7'(s + 1)) && !fl, "R6 byte1", b, pat(7'(s + 1)));
        else chk(fl == 1'b1, "R8 past window", fl, 1);
        stop_rd();
        chk(so_oe == 1'b0, "R1 after cs high", so_oe, 0);
      end
    end

    start_rd(8'h4B, 32'h0100_0003, 1'b1, 1'b0, 1'b1);
    get_byte(b, idx, fl);
    chk(fl == 1'b1, "R8 high address bits", fl, 1);
    stop_rd();

    start_rd(8'h4B, 32'd0, 1'b0, 1'b0, 1'b1);
    for (int k = 0; k < 66; k++) begin
      get_byte(b, idx, fl);
      if (k < 65) chk(b == pat(7'(k)) && !fl, "R7 long burst", b, pat(7'(k)));
      else chk(fl && idx == 7'd65, "R7 no rollover", idx, 65);
    end
    stop_rd();

    start_rd(8'h4B, 32'd12, 1'b0, 1'b1, 1'b0);
    chk(so_oe == 1'b0, "R3 busy refused", so_oe, 0);
    get_byte(b, idx, fl);
    chk(so_oe == 1'b0, "R3 busy stays off", so_oe, 0);
    stop_rd();

    start_rd(8'h4A, 32'd12, 1'b0, 1'b0, 1'b0);
    chk(so_oe == 1'b0, "R2 wrong opcode", so_oe, 0);
    get_byte(b, idx, fl);
    chk(so_oe == 1'b0, "R2 wrong opcode stays off", so_oe, 0);
    stop_rd();

    start_rd(8'h4B, 32'd5, 1'b0, 1'b0, 1'b1);
    addr4_en = 1'b1;
    tick(1'b0); tick(1'b0); tick(1'b0);
    chk(so_oe == 1'b1, "R10 mode held", so_oe, 1);
    stop_rd();
    chk(so_oe == 1'b0, "R9 abort mid-byte", so_oe, 0);
    start_rd(8'h4B, 32'd10, 1'b0, 1'b0, 1'b1);
    get_byte(b, idx, fl);
    chk(b == pat(7'd10) && idx == 7'd10, "R9 fresh after abort", b, pat(7'd10));
    stop_rd();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule